// File: doc/BRIEF.md
# Cascadable CAM Match and Full Flag Controller

This block is the flag and cascade-control logic of one content-addressable memory device that sits in a vertical chain of identical devices. It watches an active-low chip-enable strobe, sampled on a free-running system clock. On the strobe's falling edge it captures the write-select, command-select and chain-enable inputs. On the rising edge it locks the chain state for the following cycles and turns the data-bus driver off.

Compare results come from the local match array as a count of valid matches, together with a local full indication. The block keeps the device match and multiple match status from the most recent compare. It then combines that status with the upstream chain inputs to produce the active-low system-style match flag and full flag. Control-register enables can reduce either of those two outputs to a plain pass-through of its chain input. Switching the active configuration set clears all match status. The first device of a chain has its match input tied high and its full input tied low. The last device's flags are the system flags.

Top module: `cam_flag_cascade`

## Requirements
- R1: During and right after reset (rst_n low), mf_n, ma_n, mm_n and ff-related state are inactive: mf_n, ma_n and mm_n read 1, dq_oe reads 0, and lat_wr_n and lat_cmd_n read 1.
- R2: On the clock edge at which ce_n is first seen low after being high, wr_n and cmd_n are captured into lat_wr_n and lat_cmd_n, visible after that edge. They hold their value at every other edge.
- R3: dq_oe becomes 1 after the falling-strobe edge when the captured wr_n is 1 (read cycle). It is 0 after a falling-strobe edge with wr_n 0 (write cycle). It returns to 0 after the edge at which ce_n is first seen high again, and stays 0 while ce_n stays high.
- R4: At the rising-strobe edge, the chain becomes active if ec_n was captured 0 at the preceding falling-strobe edge, and inactive otherwise. While the chain is inactive, mf_n is 1 regardless of mi_n and local matches.
- R5: With the chain active and mf_en 1, mf_n is 0 when mi_n is 0 or when the device holds a valid match (ma_n 0); otherwise it is 1.
- R6: With the chain active and mf_en 0, mf_n equals mi_n.
- R7: One edge after cmp_valid is 1, ma_n becomes 0 if cmp_count is at least 1 and 1 if it is 0. It holds until the next compare, independently of ec_n and mi_n.
- R8: One edge after cmp_valid is 1, mm_n becomes 0 if cmp_count is at least 2 and 1 otherwise, and holds until the next compare.
- R9: One edge after cfg_switch is 1, ma_n, mm_n and mf_n are 1 and the chain is inactive, even if cmp_valid is 1 in the same cycle.
- R10: With ff_en 1, ff_n is 0 exactly when local_full is 1 and fi_n is 0; with ff_en 0, ff_n equals fi_n.
- R11: In a chain of devices (first with mi_n 1 and fi_n 0), the last device's mf_n reports a match in any enabled device of the chain. Its ff_n is 0 only when every device with its full flag enabled is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Active-low chip-enable strobe, sampled on clk |
| wr_n | input | 1 | Write select: 0 write, 1 read |
| cmd_n | input | 1 | Command select: 0 command, 1 data |
| ec_n | input | 1 | Active-low chain/match-flag enable |
| cmp_valid | input | 1 | Compare result strobe from the match array |
| cmp_count | input | CNT_W | Number of valid matches of this compare |
| local_full | input | 1 | No empty location remains in this device |
| cfg_switch | input | 1 | Active configuration set changed |
| mf_en | input | 1 | Control-register match-flag enable |
| ff_en | input | 1 | Control-register full-flag enable |
| mi_n | input | 1 | Upstream match input |
| fi_n | input | 1 | Upstream full input |
| mf_n | output | 1 | Chained match flag |
| ma_n | output | 1 | Device match flag |
| mm_n | output | 1 | Device multiple-match flag |
| ff_n | output | 1 | Chained full flag |
| dq_oe | output | 1 | Data-bus output enable |
| lat_wr_n | output | 1 | Captured write select |
| lat_cmd_n | output | 1 | Captured command select |

## Verification
The bench builds three instances with CNT_W set to 3, so compare counts from 0 to 7 can be drawn at random. This covers the zero, single and multiple match cases and the wide counts. Chaining three devices brings match priority through a disabled or pass-through middle device within reach. It also covers full propagation through a mix of enabled and disabled full flags, with configuration switches colliding with compares.

// File: rtl/cam_flag_pkg.sv
// Package: shared types for the CAM flag controller.
// Assumes: all control pins are active low, as captured on the strobe edge.
package cam_flag_pkg;

    // Control pins captured at the falling edge of the chip-enable strobe.
    typedef struct packed {
        logic wr_n;
        logic cmd_n;
        logic ec_n;
    } cyc_ctl_t;

    localparam cyc_ctl_t CTL_IDLE = '{wr_n: 1'b1, cmd_n: 1'b1, ec_n: 1'b1};

endpackage

// File: rtl/cfc_strobe.sv
// Module: edge detector for the chip-enable strobe.
// Assumes ce_n is synchronous to clk; the edges are reported in the cycle
// where the new level is first present on the input.
module cfc_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    output logic ce_fall,
    output logic ce_rise,
    output logic ce_idle
);
    logic ce_prev;

    // Remember the last sampled strobe level; idle high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ce_prev <= 1'b1;
        else        ce_prev <= ce_n;
    end

    // Edges compare the current input with the remembered level.
    always_comb begin
        ce_fall = ce_prev & ~ce_n;
        ce_rise = ~ce_prev & ce_n;
        ce_idle = ce_prev;
    end
endmodule

// File: rtl/cfc_cycle.sv
// Module: captures the cycle controls on the strobe falling edge, drives the
// data-bus enable and locks the chain state on the rising edge.
// Assumes a configuration switch overrides any chain update in the same cycle.
module cfc_cycle
    import cam_flag_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ce_fall,
    input  logic     ce_rise,
    input  logic     ce_idle,
    input  cyc_ctl_t ctl_in,
    input  logic     cfg_switch,
    output cyc_ctl_t ctl_q,
    output logic     dq_oe,
    output logic     chain_act
);
    // Capture the control pins only at the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctl_q <= CTL_IDLE;
        else if (ce_fall) ctl_q <= ctl_in;
    end

    // Bus enable: on for a read after the fall, off at the rise.
    always_ff @(posedge clk) begin
        if (!rst_n)       dq_oe <= 1'b0;
        else if (ce_fall) dq_oe <= ctl_in.wr_n;
        else if (ce_rise) dq_oe <= 1'b0;
    end

    // Chain state locked at the rise from the captured enable.
    always_ff @(posedge clk) begin
        if (!rst_n)          chain_act <= 1'b0;
        else if (cfg_switch) chain_act <= 1'b0;
        else if (ce_rise)    chain_act <= ~ctl_q.ec_n;
    end

    // R3: the bus is never driven once the strobe has been seen high.
    p_bus_off_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ce_idle |-> !dq_oe);

    // R2: captured controls change only at a falling edge.
    p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_fall |=> $stable(ctl_q));

    // R4: chain state moves only at a rise or configuration switch.
    p_chain_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_rise && !cfg_switch) |=> $stable(chain_act));
endmodule

// File: rtl/cfc_match.sv
// Module: device match and multiple-match status from the latest compare.
// Assumes cmp_count is the number of valid matches, meaningful with cmp_valid.
module cfc_match #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_valid,
    input  logic [CNT_W-1:0] cmp_count,
    input  logic             cfg_switch,
    output logic             hit,
    output logic             multi
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Update status per compare; a configuration switch clears it first.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_switch) begin
            hit   <= 1'b0;
            multi <= 1'b0;
        end else if (cmp_valid) begin
            hit   <= (cmp_count != '0);
            multi <= (cmp_count > ONE);
        end
    end

    // R8: a multiple match always implies a match.
    p_multi_has_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        multi |-> hit);

    // R9: the switch clears both status bits.
    p_cfg_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_switch |=> (!hit && !multi));

    // R7: status holds between compares.
    p_hit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_valid && !cfg_switch) |=> $stable(hit));
endmodule

// File: rtl/cfc_cascade.sv
// Module: merges local status with the upstream chain inputs.
// Assumes the chain inputs come from the previous device, so the paths are
// combinational through the chain with no loop.
module cfc_cascade (
    input  logic chain_act,
    input  logic hit,
    input  logic mf_en,
    input  logic mi_n,
    input  logic ff_en,
    input  logic local_full,
    input  logic fi_n,
    output logic mf_n,
    output logic ff_n
);
    logic mf_chained;
    logic ff_chained;

    // Match: upstream match or enabled local match, gated by the chain.
    always_comb begin
        mf_chained = mi_n & ~(mf_en & hit);
        mf_n       = chain_act ? mf_chained : 1'b1;
    end

    // Full: only full when upstream is full and this device is full.
    always_comb begin
        ff_chained = ~(local_full & ~fi_n);
        ff_n       = ff_en ? ff_chained : fi_n;
    end
endmodule

// File: rtl/cam_flag_cascade.sv
// Module: top of the CAM flag and cascade controller.
// Assumes ce_n, controls and chain inputs are synchronous to clk; reset is
// synchronous and active low.
module cam_flag_cascade
    import cam_flag_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             wr_n,
    input  logic             cmd_n,
    input  logic             ec_n,
    input  logic             cmp_valid,
    input  logic [CNT_W-1:0] cmp_count,
    input  logic             local_full,
    input  logic             cfg_switch,
    input  logic             mf_en,
    input  logic             ff_en,
    input  logic             mi_n,
    input  logic             fi_n,
    output logic             mf_n,
    output logic             ma_n,
    output logic             mm_n,
    output logic             ff_n,
    output logic             dq_oe,
    output logic             lat_wr_n,
    output logic             lat_cmd_n
);
    logic     ce_fall, ce_rise, ce_idle;
    logic     chain_act, hit, multi;
    cyc_ctl_t ctl_in, ctl_q;

    // Pack the raw control pins for capture.
    always_comb begin
        ctl_in.wr_n  = wr_n;
        ctl_in.cmd_n = cmd_n;
        ctl_in.ec_n  = ec_n;
    end

    cfc_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n),
        .ce_fall(ce_fall), .ce_rise(ce_rise), .ce_idle(ce_idle)
    );

    cfc_cycle u_cycle (
        .clk(clk), .rst_n(rst_n), .ce_fall(ce_fall), .ce_rise(ce_rise),
        .ce_idle(ce_idle), .ctl_in(ctl_in), .cfg_switch(cfg_switch),
        .ctl_q(ctl_q), .dq_oe(dq_oe), .chain_act(chain_act)
    );

    cfc_match #(.CNT_W(CNT_W)) u_match (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid),
        .cmp_count(cmp_count), .cfg_switch(cfg_switch),
        .hit(hit), .multi(multi)
    );

    cfc_cascade u_cascade (
        .chain_act(chain_act), .hit(hit), .mf_en(mf_en), .mi_n(mi_n),
        .ff_en(ff_en), .local_full(local_full), .fi_n(fi_n),
        .mf_n(mf_n), .ff_n(ff_n)
    );

    // Drive the device flags and captured controls.
    always_comb begin
        ma_n      = ~hit;
        mm_n      = ~multi;
        lat_wr_n  = ctl_q.wr_n;
        lat_cmd_n = ctl_q.cmd_n;
    end

    // R4: an inactive chain holds the match flag high.
    p_mf_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_act |-> mf_n);

    // R7: a compare with matches shows on the device flag next cycle.
    p_hit_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cfg_switch && cmp_count != '0) |=> !ma_n);
endmodule

// File: tb/cam_flag_cascade_tb_top.sv
// Bench: three chained devices under random and directed stimulus.
module cam_flag_cascade_tb_top;
    localparam int PERIOD = 10;
    localparam int CW     = 3;
    localparam int ND     = 3;

    logic clk = 1'b0;
    logic rst_n, ce_n, wr_n, cmd_n, ec_n, cfg_switch;
    logic [ND-1:0] cmp_valid, full, mf_en, ff_en;
    logic [ND-1:0] mf, ma, mm, ff, oe, lwr, lcmd;
    logic [CW-1:0] cnt [ND];

    int checks = 0, failures = 0;
    logic m_hit [ND], m_multi [ND];
    logic m_act;

    always #(PERIOD/2) clk = ~clk;

    cam_flag_cascade #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .cmd_n(cmd_n),
        .ec_n(ec_n), .cmp_valid(cmp_valid[0]), .cmp_count(cnt[0]),
        .local_full(full[0]), .cfg_switch(cfg_switch), .mf_en(mf_en[0]),
        .ff_en(ff_en[0]), .mi_n(1'b1), .fi_n(1'b0), .mf_n(mf[0]),
        .ma_n(ma[0]), .mm_n(mm[0]), .ff_n(ff[0]), .dq_oe(oe[0]),
        .lat_wr_n(lwr[0]), .lat_cmd_n(lcmd[0]));

    cam_flag_cascade #(.CNT_W(CW)) dut_mid_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .cmd_n(cmd_n),
        .ec_n(ec_n), .cmp_valid(cmp_valid[1]), .cmp_count(cnt[1]),
        .local_full(full[1]), .cfg_switch(cfg_switch), .mf_en(mf_en[1]),
        .ff_en(ff_en[1]), .mi_n(mf[0]), .fi_n(ff[0]), .mf_n(mf[1]),
        .ma_n(ma[1]), .mm_n(mm[1]), .ff_n(ff[1]), .dq_oe(oe[1]),
        .lat_wr_n(lwr[1]), .lat_cmd_n(lcmd[1]));

    cam_flag_cascade #(.CNT_W(CW)) dut_tail_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .cmd_n(cmd_n),
        .ec_n(ec_n), .cmp_valid(cmp_valid[2]), .cmp_count(cnt[2]),
        .local_full(full[2]), .cfg_switch(cfg_switch), .mf_en(mf_en[2]),
        .ff_en(ff_en[2]), .mi_n(mf[1]), .fi_n(ff[1]), .mf_n(mf[2]),
        .ma_n(ma[2]), .mm_n(mm[2]), .ff_n(ff[2]), .dq_oe(oe[2]),
        .lat_wr_n(lwr[2]), .lat_cmd_n(lcmd[2]));

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Expected match flag of device d from the chain model (R4, R5, R6, R11).
    function automatic logic exp_mf(input int d);
        logic up = 1'b1;
        logic cur = 1'b1;
        for (int i = 0; i <= d; i++) begin
            cur = m_act ? (up & ~(mf_en[i] & m_hit[i])) : 1'b1;
            up  = cur;
        end
        return cur;
    endfunction

    // Expected full flag of device d (R10, R11).
    function automatic logic exp_ff(input int d);
        logic up = 1'b0;
        logic cur = 1'b0;
        for (int i = 0; i <= d; i++) begin
            cur = ff_en[i] ? ~(full[i] & ~up) : up;
            up  = cur;
        end
        return cur;
    endfunction

    task automatic check_flags(input string tag);
        for (int d = 0; d < ND; d++) begin
            check(m_act ? (tag == "" ? "R5" : tag) : "R4", $sformatf("mf dev%0d", d), mf[d], exp_mf(d));
            check("R7", $sformatf("ma dev%0d", d), ma[d], ~m_hit[d]);
            check("R8", $sformatf("mm dev%0d", d), mm[d], ~m_multi[d]);
            check("R10", $sformatf("ff dev%0d", d), ff[d], exp_ff(d));
        end
        check("R11", "system mf", mf[ND-1], exp_mf(ND-1));
        check("R11", "system ff", ff[ND-1], exp_ff(ND-1));
    endtask

    // One compare across the chain, optionally with a configuration switch.
    task automatic do_compare(input logic [CW-1:0] c0, input logic [CW-1:0] c1,
                              input logic [CW-1:0] c2, input logic cfg);
        @(negedge clk);
        cnt[0] = c0; cnt[1] = c1; cnt[2] = c2;
        cmp_valid = '1; cfg_switch = cfg;
        @(negedge clk);
        cmp_valid = '0; cfg_switch = 1'b0;
        for (int d = 0; d < ND; d++) begin
            m_hit[d]   = cfg ? 1'b0 : (cnt[d] != 0);
            m_multi[d] = cfg ? 1'b0 : (cnt[d] > 1);
        end
        if (cfg) m_act = 1'b0;
        if (cfg) for (int d = 0; d < ND; d++) check("R9", "mf after switch", mf[d], 1'b1);
    endtask

    // One strobe cycle: fall, check capture, rise, check release.
    task automatic bus_cycle(input logic w, input logic c, input logic e);
        @(negedge clk);
        ce_n = 1'b0; wr_n = w; cmd_n = c; ec_n = e;
        @(negedge clk);
        check("R2", "lat_wr_n", lwr[ND-1], w);
        check("R2", "lat_cmd_n", lcmd[0], c);
        check("R3", "dq_oe during cycle", oe[0], w);
        wr_n = ~w; cmd_n = ~c; ec_n = ~e;
        ce_n = 1'b1;
        @(negedge clk);
        check("R3", "dq_oe after rise", oe[1], 1'b0);
        check("R2", "lat_wr_n held", lwr[0], w);
        m_act = ~e;
        @(negedge clk);
        check("R3", "dq_oe idle", oe[2], 1'b0);
    endtask

    initial begin
        #(PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        rst_n = 1'b0; ce_n = 1'b1; wr_n = 1'b1; cmd_n = 1'b1; ec_n = 1'b1;
        cfg_switch = 1'b0; cmp_valid = '0; full = '0; mf_en = '1; ff_en = '1;
        for (int d = 0; d < ND; d++) begin
            cnt[d] = '0; m_hit[d] = 1'b0; m_multi[d] = 1'b0;
        end
        m_act = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1", "mf", mf[0], 1'b1);
        check("R1", "ma", ma[1], 1'b1);
        check("R1", "mm", mm[2], 1'b1);
        check("R1", "dq_oe", oe[0], 1'b0);
        check("R1", "lat_wr_n", lwr[0], 1'b1);
        check("R1", "lat_cmd_n", lcmd[0], 1'b1);
        rst_n = 1'b1;

        // Directed: single match in the middle, chain disabled then enabled.
        do_compare(3'd0, 3'd1, 3'd0, 1'b0);
        #1 check_flags("R7");
        bus_cycle(1'b1, 1'b0, 1'b1);
        #1 check("R4", "mf gated", mf[2], 1'b1);
        bus_cycle(1'b0, 1'b1, 1'b0);
        #1 check_flags("R5");
        // R6: middle disabled passes upstream; head match reaches the tail.
        do_compare(3'd2, 3'd0, 3'd0, 1'b0);
        @(negedge clk); mf_en = 3'b101;
        #1 check("R6", "pass-through mid", mf[1], mf[0]);
        check_flags("R6");
        // R9: switch collides with a compare.
        do_compare(3'd7, 3'd7, 3'd7, 1'b1);
        #1 check_flags("R9");
        // R10: full propagation with all full then a gap.
        @(negedge clk); full = 3'b111; ff_en = 3'b111;
        #1 check("R10", "system full", ff[2], 1'b0);
        full = 3'b101;
        #1 check("R10", "gap not full", ff[2], 1'b1);
        ff_en = 3'b101;
        #1 check("R10", "mid pass-through", ff[1], ff[0]);

        // Random phase.
        for (int it = 0; it < 400; it++) begin
            do_compare(CW'($urandom), CW'($urandom), CW'($urandom),
                       ($urandom % 16) == 0);
            #1 check_flags("");
            bus_cycle(1'($urandom), 1'($urandom), 1'(($urandom % 3) == 0));
            @(negedge clk);
            full = 3'($urandom); mf_en = 3'($urandom); ff_en = 3'($urandom);
            #1 check_flags("");
        end
        finish_run();
    end
endmodule